// File: doc/BRIEF.md
# Inter-layer Motion Data Upsampler

This block produces motion data for a macroblock of a spatial enhancement layer from the co-located 8x8 block of a base layer at half resolution. For each base-layer motion vector it maps the base partition shape to the enhancement macroblock shape by doubling both dimensions. It doubles the vector components. In refinement mode it adds a quarter-sample correction of minus one, zero or plus one to each component. It saturates the result to the output width and passes the reference picture index through unchanged.

One vector is accepted per clock through a valid/ready handshake. The result sits in a registered output stage that holds its value until the consumer takes it. When the base block is intra coded, the output carries a flag that marks the result as unusable for motion prediction, and both vector components are forced to zero. A refinement code with no defined meaning raises an error flag and is applied as zero.

Top module: `ilmu_top`

## Requirements
- R1: The input partition code (0 = 8x8, 1 = 8x4, 2 = 4x8, 3 = 4x4) maps to the output code 0 = 16x16, 1 = 16x8, 2 = 8x16, 3 = 8x8 respectively.
- R2: When `mode_refine` is 0, each output component equals twice the input component and both refinement codes are ignored (`refine_err` stays 0).
- R3: When `mode_refine` is 1, each output component equals twice the input component plus the decoded refinement, where the 2-bit code 2'b00 means 0, 2'b01 means +1 and 2'b11 means -1.
- R4: When `mode_refine` is 1 and either refinement code is 2'b10, `refine_err` is 1 and that component is refined by 0.
- R5: Output components are saturated to the range -2^(OUT_W-1) to 2^(OUT_W-1)-1.
- R6: `out_ref_idx` equals the `ref_idx` of the accepted input.
- R7: When `base_intra` is 1, `no_pred` is 1 and both output components are 0. The partition mapping, the reference index and the refinement error still follow R1, R6 and R4.
- R8: `in_ready` is high when the output stage is empty or `out_ready` is high. An input accepted on a clock edge appears at the outputs with `out_valid` high right after that edge, and the output stays unchanged while `out_valid` is high and `out_ready` is low.
- R9: After a synchronous reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input vector present |
| in_ready | output | 1 | Block can take an input this cycle |
| base_part | input | 2 | Base 8x8 block partition code |
| base_intra | input | 1 | Base block is intra coded |
| mode_refine | input | 1 | 0 = use scaled vector only, 1 = add refinement |
| mv_x | input | IN_W | Base horizontal component, signed |
| mv_y | input | IN_W | Base vertical component, signed |
| ref_x | input | 2 | Horizontal refinement code |
| ref_y | input | 2 | Vertical refinement code |
| ref_idx | input | REF_W | Reference picture index |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| mb_part | output | 2 | Enhancement macroblock partition code |
| out_mv_x | output | OUT_W | Scaled horizontal component, signed |
| out_mv_y | output | OUT_W | Scaled vertical component, signed |
| out_ref_idx | output | REF_W | Passed-through reference index |
| no_pred | output | 1 | Result not usable for motion prediction |
| refine_err | output | 1 | Undefined refinement code seen |

## Verification
Every result is due on the first clock edge after its input is accepted, so it becomes visible one register stage later. A stalled result must stay put for as many cycles as `out_ready` is held low. The bench keeps its own one-entry model of the output stage. At each falling edge it compares the outputs with that model, then drives new inputs, checks `in_ready` a moment later, and finally advances the model with the acceptance decision the requirements predict. Random traffic with random back-pressure is mixed with directed saturation, intra, undefined-code and partition cases.

// File: rtl/ilmu_pkg.sv
package ilmu_pkg;

  typedef enum logic [1:0] {
    BP_8X8 = 2'd0,
    BP_8X4 = 2'd1,
    BP_4X8 = 2'd2,
    BP_4X4 = 2'd3
  } base_part_e;

  typedef enum logic [1:0] {
    MB_16X16 = 2'd0,
    MB_16X8  = 2'd1,
    MB_8X16  = 2'd2,
    MB_8X8   = 2'd3
  } mb_part_e;

  // Refinement code: 00 -> 0, 01 -> +1, 11 -> -1, 10 -> undefined (used as 0)
  function automatic logic [1:0] refine_value(input logic [1:0] code);
    case (code)
      2'b01:   refine_value = 2'b01;
      2'b11:   refine_value = 2'b11;
      default: refine_value = 2'b00;
    endcase
  endfunction

  function automatic logic refine_bad(input logic [1:0] code);
    refine_bad = (code == 2'b10);
  endfunction

endpackage

// File: rtl/ilmu_part_map.sv
module ilmu_part_map
  import ilmu_pkg::*;
(
  input  logic [1:0] base_code,
  output logic [1:0] mb_code
);
  base_part_e bp;
  mb_part_e   mp;

  always_comb begin
    bp = base_part_e'(base_code);
    case (bp)
      BP_8X8:  mp = MB_16X16;
      BP_8X4:  mp = MB_16X8;
      BP_4X8:  mp = MB_8X16;
      default: mp = MB_8X8;
    endcase
    mb_code = mp;
  end
endmodule

// File: rtl/ilmu_mv_scale.sv
module ilmu_mv_scale
  import ilmu_pkg::*;
#(
  parameter int IN_W  = 12,
  parameter int OUT_W = 12
) (
  input  logic [IN_W-1:0]  mv_in,
  input  logic [1:0]       code,
  input  logic             refine_en,
  input  logic             force_zero,
  output logic [OUT_W-1:0] mv_out,
  output logic             code_err
);
  localparam int SW = IN_W + 2;

  logic signed [SW-1:0] ext;
  logic signed [SW-1:0] rext;
  logic signed [SW-1:0] sum;
  logic [1:0]           rdec;
  logic [OUT_W-1:0]     limited;

  always_comb begin
    rdec     = refine_en ? refine_value(code) : 2'b00;
    code_err = refine_en && refine_bad(code);
    ext      = {{2{mv_in[IN_W-1]}}, mv_in};
    rext     = {{(SW-2){rdec[1]}}, rdec};
    sum      = (ext <<< 1) + rext;
  end

  generate
    if (OUT_W >= SW) begin : g_wide
      always_comb limited = {{(OUT_W-SW){sum[SW-1]}}, sum};
    end else begin : g_sat
      localparam logic signed [SW-1:0] MAXV = {{(SW-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
      localparam logic signed [SW-1:0] MINV = {{(SW-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};
      always_comb begin
        if (sum > MAXV)      limited = MAXV[OUT_W-1:0];
        else if (sum < MINV) limited = MINV[OUT_W-1:0];
        else                 limited = sum[OUT_W-1:0];
      end
    end
  endgenerate

  assign mv_out = force_zero ? '0 : limited;
endmodule

// File: rtl/ilmu_out_stage.sv
module ilmu_out_stage #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [PW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] out_data
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) out_data <= in_data;
  end

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (rst)
    take |=> (out_valid && out_data == $past(in_data))); // R8
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8
endmodule

// File: rtl/ilmu_top.sv
module ilmu_top
  import ilmu_pkg::*;
#(
  parameter int IN_W  = 12,
  parameter int OUT_W = 12,
  parameter int REF_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       base_part,
  input  logic             base_intra,
  input  logic             mode_refine,
  input  logic [IN_W-1:0]  mv_x,
  input  logic [IN_W-1:0]  mv_y,
  input  logic [1:0]       ref_x,
  input  logic [1:0]       ref_y,
  input  logic [REF_W-1:0] ref_idx,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [1:0]       mb_part,
  output logic [OUT_W-1:0] out_mv_x,
  output logic [OUT_W-1:0] out_mv_y,
  output logic [REF_W-1:0] out_ref_idx,
  output logic             no_pred,
  output logic             refine_err
);
  localparam int NCOMP = 2;
  localparam int PW    = 2 + NCOMP*OUT_W + REF_W + 2;
  localparam logic [OUT_W-1:0] MAXO = {1'b0, {(OUT_W-1){1'b1}}};

  logic [1:0]       part_c;
  logic [IN_W-1:0]  comp_in  [NCOMP];
  logic [1:0]       comp_cd  [NCOMP];
  logic [OUT_W-1:0] comp_out [NCOMP];
  logic [NCOMP-1:0] comp_err;
  logic [PW-1:0]    pay_in, pay_out;

  assign comp_in[0] = mv_x;
  assign comp_in[1] = mv_y;
  assign comp_cd[0] = ref_x;
  assign comp_cd[1] = ref_y;

  ilmu_part_map u_part (
    .base_code (base_part),
    .mb_code   (part_c)
  );

  generate
    for (genvar i = 0; i < NCOMP; i++) begin : g_comp
      ilmu_mv_scale #(.IN_W(IN_W), .OUT_W(OUT_W)) u_scale (
        .mv_in      (comp_in[i]),
        .code       (comp_cd[i]),
        .refine_en  (mode_refine),
        .force_zero (base_intra),
        .mv_out     (comp_out[i]),
        .code_err   (comp_err[i])
      );
    end
  endgenerate

  assign pay_in = {part_c, comp_out[0], comp_out[1], ref_idx, base_intra, |comp_err};

  ilmu_out_stage #(.PW(PW)) u_stage (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (pay_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pay_out)
  );

  assign {mb_part, out_mv_x, out_mv_y, out_ref_idx, no_pred, refine_err} = pay_out;

  logic accept;
  assign accept = in_valid && in_ready;

  AST_INTRA_ZERO: assert property (@(posedge clk) disable iff (rst)
    (out_valid && no_pred) |-> (out_mv_x == '0 && out_mv_y == '0)); // R7
  AST_BASE_EVEN: assert property (@(posedge clk) disable iff (rst)
    (accept && !mode_refine && !base_intra) |=> (out_mv_x[0] == 1'b0 || out_mv_x == MAXO)); // R2
  AST_BASE_NO_ERR: assert property (@(posedge clk) disable iff (rst)
    (accept && !mode_refine) |=> !refine_err); // R2
  AST_BAD_CODE_ERR: assert property (@(posedge clk) disable iff (rst)
    (accept && mode_refine && (ref_x == 2'b10 || ref_y == 2'b10)) |=> refine_err); // R4
  AST_REF_PASS: assert property (@(posedge clk) disable iff (rst)
    accept |=> (out_ref_idx == $past(ref_idx))); // R6
endmodule

// File: tb/ilmu_top_tb.sv
module ilmu_top_tb;
  localparam int IN_W  = 12;
  localparam int OUT_W = 12;
  localparam int REF_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_ready;
  logic [1:0] base_part = '0;
  logic base_intra = 1'b0, mode_refine = 1'b0;
  logic [IN_W-1:0] mv_x = '0, mv_y = '0;
  logic [1:0] ref_x = '0, ref_y = '0;
  logic [REF_W-1:0] ref_idx = '0;
  logic out_valid, out_ready = 1'b0;
  logic [1:0] mb_part;
  logic [OUT_W-1:0] out_mv_x, out_mv_y;
  logic [REF_W-1:0] out_ref_idx;
  logic no_pred, refine_err;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // model of the output stage
  bit               e_valid = 1'b0;
  logic [1:0]       e_part;
  logic [OUT_W-1:0] e_mx, e_my;
  logic [REF_W-1:0] e_ref;
  logic             e_np, e_err;

  always #10 clk = ~clk;

  ilmu_top #(.IN_W(IN_W), .OUT_W(OUT_W), .REF_W(REF_W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .base_part(base_part), .base_intra(base_intra), .mode_refine(mode_refine),
    .mv_x(mv_x), .mv_y(mv_y), .ref_x(ref_x), .ref_y(ref_y), .ref_idx(ref_idx),
    .out_valid(out_valid), .out_ready(out_ready), .mb_part(mb_part),
    .out_mv_x(out_mv_x), .out_mv_y(out_mv_y), .out_ref_idx(out_ref_idx),
    .no_pred(no_pred), .refine_err(refine_err)
  );

  function automatic logic [OUT_W-1:0] exp_mv(input logic [IN_W-1:0] mv, input logic [1:0] code,
                                              input logic refine, input logic intra);
    int v, hi, lo;
    v  = 2 * int'($signed(mv));
    if (refine && code == 2'b01) v = v + 1;
    if (refine && code == 2'b11) v = v - 1;
    hi = (1 << (OUT_W-1)) - 1;
    lo = -(1 << (OUT_W-1));
    if (v > hi) v = hi;
    if (v < lo) v = lo;
    if (intra) v = 0;
    return OUT_W'(v);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic v, input logic [1:0] p, input logic intra, input logic md,
                      input logic [IN_W-1:0] x, input logic [IN_W-1:0] y,
                      input logic [1:0] rx, input logic [1:0] ry,
                      input logic [REF_W-1:0] ri, input logic rdy);
    bit exp_rdy;
    string mvreq;
    @(negedge clk);
    chk("R8 out_valid", int'(out_valid), int'(e_valid));
    if (e_valid) begin
      mvreq = e_np ? "R7 mv" : "R2/R3/R5 mv";
      chk("R1 mb_part", int'(mb_part), int'(e_part));
      chk({mvreq, " x"}, int'(out_mv_x), int'(e_mx));
      chk({mvreq, " y"}, int'(out_mv_y), int'(e_my));
      chk("R6 ref_idx", int'(out_ref_idx), int'(e_ref));
      chk("R7 no_pred", int'(no_pred), int'(e_np));
      chk("R4 refine_err", int'(refine_err), int'(e_err));
    end
    in_valid = v; base_part = p; base_intra = intra; mode_refine = md;
    mv_x = x; mv_y = y; ref_x = rx; ref_y = ry; ref_idx = ri; out_ready = rdy;
    #1;
    exp_rdy = !e_valid || rdy;
    chk("R8 in_ready", int'(in_ready), int'(exp_rdy));
    if (v && exp_rdy) begin
      e_valid = 1'b1;
      e_part  = p;
      e_mx    = exp_mv(x, rx, md, intra);
      e_my    = exp_mv(y, ry, md, intra);
      e_ref   = ri;
      e_np    = intra;
      e_err   = md && (rx == 2'b10 || ry == 2'b10);
    end else if (rdy) begin
      e_valid = 1'b0;
    end
  endtask

  localparam logic [IN_W-1:0] MAXI = {1'b0, {(IN_W-1){1'b1}}};
  localparam logic [IN_W-1:0] MINI = {1'b1, {(IN_W-1){1'b0}}};

  initial begin
    int seed;
    seed = $urandom(32'h5EED_0042);
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 out_valid after reset", int'(out_valid), 0);
    chk("R9 in_ready after reset", int'(in_ready), 1);
    // R1: every partition code
    for (int p = 0; p < 4; p++)
      step(1, 2'(p), 0, 0, 12'd5, 12'hFFD, 2'b01, 2'b11, 4'(p), 1);
    // R2: refinements ignored in base mode
    step(1, 0, 0, 0, 12'd100, 12'hF9C, 2'b10, 2'b01, 4'd3, 1);
    // R3: +1 and -1
    step(1, 1, 0, 1, 12'd7, 12'd7, 2'b01, 2'b11, 4'd9, 1);
    // R4: undefined code
    step(1, 2, 0, 1, 12'd9, 12'hFF0, 2'b10, 2'b00, 4'd1, 1);
    step(1, 3, 0, 1, 12'd9, 12'hFF0, 2'b11, 2'b10, 4'd2, 1);
    // R5: saturation both ends, with and without refinement
    step(1, 0, 0, 1, MAXI, MINI, 2'b01, 2'b11, 4'd4, 1);
    step(1, 0, 0, 0, 12'd1024, 12'hBFF, 2'b00, 2'b00, 4'd5, 1);
    step(1, 0, 0, 1, 12'd1023, 12'hC00, 2'b01, 2'b11, 4'd6, 1);
    // R7: intra
    step(1, 2, 1, 1, 12'd33, 12'hF00, 2'b10, 2'b01, 4'd15, 1);
    step(1, 1, 1, 0, MAXI, MINI, 2'b00, 2'b00, 4'd8, 1);
    // R8: stall holds the result
    step(1, 3, 0, 1, 12'd12, 12'd13, 2'b01, 2'b00, 4'd10, 0);
    step(1, 0, 0, 0, 12'd44, 12'd45, 2'b00, 2'b00, 4'd11, 0);
    step(0, 0, 0, 0, 12'd0, 12'd0, 2'b00, 2'b00, 4'd0, 0);
    step(0, 0, 0, 0, 12'd0, 12'd0, 2'b00, 2'b00, 4'd0, 1);
    step(0, 0, 0, 0, 12'd0, 12'd0, 2'b00, 2'b00, 4'd0, 1);
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [IN_W-1:0] rx_v, ry_v;
      rx_v = IN_W'($urandom);
      ry_v = IN_W'($urandom);
      if ($urandom_range(0, 7) == 0) rx_v = ($urandom_range(0, 1) == 1) ? MAXI : MINI;
      step(1'($urandom_range(0, 3) != 0), 2'($urandom), 1'($urandom_range(0, 7) == 0),
           1'($urandom), rx_v, ry_v, 2'($urandom), 2'($urandom), REF_W'($urandom),
           1'($urandom_range(0, 3) != 0));
    end
    step(0, 0, 0, 0, 12'd0, 12'd0, 2'b00, 2'b00, 4'd0, 1);
    step(0, 0, 0, 0, 12'd0, 12'd0, 2'b00, 2'b00, 4'd0, 1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule